// File: doc/BRIEF.md
# Directory Home Coherence Controller

This block is the home-node side of a coherence protocol that keeps track of sharers in a directory instead of broadcasting. It serves a small, fixed set of nodes. For every line homed in its memory it keeps a directory entry. An entry records one of two things: a single owner that holds the line dirty, or a bit vector of nodes that hold clean copies. Nodes send two kinds of request: a read (the node wants a shared copy) and a read-exclusive (the node wants to write).

The controller handles one transaction at a time. For a request it looks up the entry and works out which nodes hold copies that conflict with the request. It sends an invalidate or a recall to each of those nodes only, one message per cycle. It counts their acknowledgements down, and only then sends the data fill to the requester. A dirty acknowledgement carries the line data, which the controller writes into backing memory before the fill reads it back.

The backing memory sits outside the block. It is reached through a line address and a read-data bus that is read combinationally, plus a write strobe. All outgoing messages share one port, and each message is tagged with a destination node and a kind.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and msg_valid and mem_we are 0. Every directory entry is Invalid, so the first request to any line causes no invalidate or recall.
- R2: A read to a line that is Invalid or Shared is answered with one fill of kind 0 (shared fill) carrying the memory data, and with no other message. The requester is added to the line's sharer set.
- R3: A read-exclusive to a line with sharers other than the requester sends one message of kind 2 (invalidate), with zero data, to each of those other sharers. The messages go out in ascending node index, one per cycle, and no message goes to any other node.
- R4: The fill is not sent until every awaited node has acknowledged. An acknowledgement from a node that is not awaited is ignored: it neither completes the wait nor writes memory.
- R5: After a fill of kind 1 (exclusive fill), the line is Modified with the requester as its only holder. A later request by another node snoops that owner alone.
- R6: A read to a Modified line owned by another node sends one message of kind 3 (recall) to the owner. The owner's dirty acknowledgement data is written to memory and returned in the shared fill. The line then becomes Shared by both the owner and the requester.
- R7: A read-exclusive to a Modified line owned by another node sends an invalidate to the owner. The owner's dirty data is written to memory and returned in the exclusive fill.
- R8: A read-exclusive from a node that is the only sharer, or that is already the owner, is granted with an exclusive fill and no invalidate.
- R9: Once a request is accepted, req_ready stays 0 until the fill has been sent. It is 1 again in the cycle after the fill.
- R10: When no snoop is needed, the fill appears in the second cycle after the clock edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_node | input | NID_W | Requesting node index |
| req_line | input | LINE_W | Line index within this home |
| req_excl | input | 1 | 1 = read-exclusive, 0 = read |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_node | output | NID_W | Destination node |
| msg_kind | output | 2 | 0 shared fill, 1 exclusive fill, 2 invalidate, 3 recall |
| msg_line | output | LINE_W | Line the message concerns |
| msg_data | output | DATA_W | Fill data (zero for snoops) |
| ack_valid | input | 1 | Acknowledgement from a node |
| ack_node | input | NID_W | Acknowledging node |
| ack_dirty | input | 1 | Acknowledgement carries dirty data |
| ack_data | input | DATA_W | Dirty line data |
| mem_line | output | LINE_W | Backing memory line address |
| mem_rdata | input | DATA_W | Backing memory read data (combinational) |
| mem_we | output | 1 | Backing memory write strobe |
| mem_wdata | output | DATA_W | Backing memory write data |

## Verification
The bench first drives reads to lines that no node holds. These tell the plain memory fill and its two-cycle latency apart from any snooping path. Next, a write request hits a line with three clean sharers. This checks that the invalidates go only to recorded holders and in index order. While those acknowledgements are pending, a stray dirty acknowledgement arrives from a node that was never asked; a fill that comes early, or corrupted memory data, would show that the stray was counted. Reads and writes to lines held dirty by another node separate the recall-and-share path from the invalidate-and-forward path. Upgrades by the sole sharer and by the current owner confirm that no snoop is sent when no other node holds the line.

// File: rtl/dirhome_pkg.sv
package dirhome_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    MK_FILL_SHR = 2'd0,
    MK_FILL_EXC = 2'd1,
    MK_INVAL    = 2'd2,
    MK_RECALL   = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    HS_IDLE = 3'd0,
    HS_ACT  = 3'd1,
    HS_SEND = 3'd2,
    HS_WAIT = 3'd3,
    HS_FILL = 3'd4
  } home_st_e;

endpackage

// File: rtl/dir_table.sv
module dir_table
  import dirhome_pkg::*;
#(
  parameter int NODES = 4,
  parameter int LINES = 8,
  localparam int NID_W  = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  output line_st_e          rd_state,
  output logic [NODES-1:0]  rd_sharers,
  output logic              rd_own_vld,
  output logic [NID_W-1:0]  rd_owner,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  line_st_e          wr_state,
  input  logic [NODES-1:0]  wr_sharers,
  input  logic              wr_own_vld,
  input  logic [NID_W-1:0]  wr_owner
);

  line_st_e         st_q  [LINES];
  logic [NODES-1:0] sh_q  [LINES];
  logic             ov_q  [LINES];
  logic [NID_W-1:0] own_q [LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rst_n) begin
        st_q[i]  <= LS_INV;
        sh_q[i]  <= '0;
        ov_q[i]  <= 1'b0;
        own_q[i] <= '0;
      end else if (wr_en && (wr_line == LINE_W'(i))) begin
        st_q[i]  <= wr_state;
        sh_q[i]  <= wr_sharers;
        ov_q[i]  <= wr_own_vld;
        own_q[i] <= wr_owner;
      end
    end
  end

  assign rd_state   = st_q[rd_line];
  assign rd_sharers = sh_q[rd_line];
  assign rd_own_vld = ov_q[rd_line];
  assign rd_owner   = own_q[rd_line];

  for (genvar g = 0; g < LINES; g++) begin : g_entry_chk
    // R5: a Modified entry names exactly one owner and no clean sharers
    a_r5_mod_single_owner : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == LS_MOD) |-> (ov_q[g] && (sh_q[g] == '0)));
    // R2: a Shared entry has at least one sharer and no owner
    a_r2_shared_has_holder : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == LS_SHR) |-> (!ov_q[g] && (sh_q[g] != '0)));
  end

endmodule

// File: rtl/node_pick.sv
module node_pick #(
  parameter int NODES = 4,
  localparam int NID_W = $clog2(NODES)
) (
  input  logic [NODES-1:0] vec,
  output logic [NID_W-1:0] idx
);

  // lowest set bit wins
  always_comb begin
    idx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (vec[i]) idx = NID_W'(i);
    end
  end

endmodule

// File: rtl/ack_track.sv
module ack_track #(
  parameter int NODES = 4,
  localparam int NID_W = $clog2(NODES),
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NODES-1:0]  load_mask,
  input  logic              issue,
  input  logic [NID_W-1:0]  issue_idx,
  input  logic              ack_valid,
  input  logic [NID_W-1:0]  ack_node,
  output logic [NODES-1:0]  todo,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic              ack_hit
);

  logic [NODES-1:0] todo_q, wait_q;

  function automatic logic [CNT_W-1:0] count_ones(input logic [NODES-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NODES; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  assign ack_hit  = ack_valid && wait_q[ack_node];
  assign todo     = todo_q;
  assign pend_cnt = count_ones(todo_q | wait_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      todo_q <= '0;
      wait_q <= '0;
    end else if (load) begin
      todo_q <= load_mask;
      wait_q <= '0;
    end else begin
      if (issue) begin
        todo_q[issue_idx] <= 1'b0;
        wait_q[issue_idx] <= 1'b1;
      end
      if (ack_hit) wait_q[ack_node] <= 1'b0;
    end
  end

  // R3: a node is never snooped again while its acknowledgement is awaited
  a_r3_no_double_issue : assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (todo_q[issue_idx] && !wait_q[issue_idx]));

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import dirhome_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int NID_W  = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NID_W-1:0]  req_node,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_excl,
  output logic              msg_valid,
  output logic [NID_W-1:0]  msg_node,
  output logic [1:0]        msg_kind,
  output logic [LINE_W-1:0] msg_line,
  output logic [DATA_W-1:0] msg_data,
  input  logic              ack_valid,
  input  logic [NID_W-1:0]  ack_node,
  input  logic              ack_dirty,
  input  logic [DATA_W-1:0] ack_data,
  output logic [LINE_W-1:0] mem_line,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata
);

  function automatic logic [NODES-1:0] node_bit(input logic [NID_W-1:0] n);
    logic [NODES-1:0] b;
    b = '0;
    b[n] = 1'b1;
    return b;
  endfunction

  home_st_e          st_q, st_d;
  logic [NID_W-1:0]  cur_node_q;
  logic [LINE_W-1:0] cur_line_q;
  logic              cur_excl_q;
  msg_kind_e         snoop_kind_q, snoop_kind_d;
  logic [NODES-1:0]  keep_q;

  line_st_e          rd_state;
  logic [NODES-1:0]  rd_sharers;
  logic              rd_own_vld;
  logic [NID_W-1:0]  rd_owner;

  logic [NODES-1:0]  holders, tgt_mask, todo;
  logic [NID_W-1:0]  pick_idx;
  logic [CNT_W-1:0]  pend_cnt;
  logic              ack_hit;

  // named events
  logic req_fire, snoop_fire, fill_fire, act_cycle, last_snoop;

  assign req_ready  = (st_q == HS_IDLE);
  assign req_fire   = req_valid && req_ready;
  assign act_cycle  = (st_q == HS_ACT);
  assign snoop_fire = (st_q == HS_SEND);
  assign fill_fire  = (st_q == HS_FILL);
  assign last_snoop = ((todo & ~node_bit(pick_idx)) == '0);

  dir_table #(.NODES(NODES), .LINES(LINES)) table_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_line    (cur_line_q),
    .rd_state   (rd_state),
    .rd_sharers (rd_sharers),
    .rd_own_vld (rd_own_vld),
    .rd_owner   (rd_owner),
    .wr_en      (fill_fire),
    .wr_line    (cur_line_q),
    .wr_state   (cur_excl_q ? LS_MOD : LS_SHR),
    .wr_sharers (cur_excl_q ? '0 : (keep_q | node_bit(cur_node_q))),
    .wr_own_vld (cur_excl_q),
    .wr_owner   (cur_node_q)
  );

  // holders of the line and the nodes that must be snooped
  always_comb begin
    holders      = rd_own_vld ? node_bit(rd_owner) : rd_sharers;
    tgt_mask     = '0;
    snoop_kind_d = MK_RECALL;
    if (cur_excl_q) begin
      tgt_mask     = holders & ~node_bit(cur_node_q);
      snoop_kind_d = MK_INVAL;
    end else if ((rd_state == LS_MOD) && (rd_owner != cur_node_q)) begin
      tgt_mask     = holders;
      snoop_kind_d = MK_RECALL;
    end
  end

  node_pick #(.NODES(NODES)) pick_i (
    .vec (todo),
    .idx (pick_idx)
  );

  ack_track #(.NODES(NODES)) track_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (act_cycle),
    .load_mask (tgt_mask),
    .issue     (snoop_fire),
    .issue_idx (pick_idx),
    .ack_valid (ack_valid),
    .ack_node  (ack_node),
    .todo      (todo),
    .pend_cnt  (pend_cnt),
    .ack_hit   (ack_hit)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      HS_IDLE: if (req_fire) st_d = HS_ACT;
      HS_ACT:  st_d = (tgt_mask != '0) ? HS_SEND : HS_FILL;
      HS_SEND: if (last_snoop) st_d = HS_WAIT;
      HS_WAIT: if (pend_cnt == '0) st_d = HS_FILL;
      HS_FILL: st_d = HS_IDLE;
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= HS_IDLE;
      cur_node_q   <= '0;
      cur_line_q   <= '0;
      cur_excl_q   <= 1'b0;
      snoop_kind_q <= MK_RECALL;
      keep_q       <= '0;
    end else begin
      st_q <= st_d;
      if (req_fire) begin
        cur_node_q <= req_node;
        cur_line_q <= req_line;
        cur_excl_q <= req_excl;
      end
      if (act_cycle) begin
        snoop_kind_q <= snoop_kind_d;
        keep_q       <= holders;
      end
    end
  end

  assign msg_valid = snoop_fire || fill_fire;
  assign msg_node  = snoop_fire ? pick_idx : cur_node_q;
  assign msg_kind  = snoop_fire ? snoop_kind_q : (cur_excl_q ? MK_FILL_EXC : MK_FILL_SHR);
  assign msg_line  = cur_line_q;
  assign msg_data  = fill_fire ? mem_rdata : '0;

  assign mem_line  = cur_line_q;
  assign mem_we    = ack_hit && ack_dirty;
  assign mem_wdata = ack_data;

  // R9: controller returns to accepting right after the fill
  a_r9_ready_after_fill : assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> req_ready);
  // R4: no fill while an invalidate or recall is outstanding
  a_r4_fill_no_pending : assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |-> (pend_cnt == '0));
  // R3: snoops never target the requester
  a_r3_snoop_not_requester : assert property (@(posedge clk) disable iff (!rst_n)
    snoop_fire |-> (msg_node != cur_node_q));
  // R6: memory is written only while acknowledgements are being collected
  a_r6_wb_only_waiting : assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((st_q == HS_SEND) || (st_q == HS_WAIT)));
  // R10: the lookup cycle after acceptance sends nothing
  a_r10_lookup_silent : assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !msg_valid);
  // R8: nothing to snoop leads straight to the fill
  a_r8_grant_direct : assert property (@(posedge clk) disable iff (!rst_n)
    (act_cycle && (tgt_mask == '0)) |=> fill_fire);

endmodule

// File: tb/home_dir_ctrl_tb_top.sv
module home_dir_ctrl_tb_top;

  localparam int NODES = 4;
  localparam int LINES = 8;
  localparam int DW    = 32;
  localparam int NW    = $clog2(NODES);
  localparam int LW    = $clog2(LINES);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_excl;
  logic [NW-1:0] req_node;
  logic [LW-1:0] req_line;
  logic          msg_valid;
  logic [NW-1:0] msg_node;
  logic [1:0]    msg_kind;
  logic [LW-1:0] msg_line;
  logic [DW-1:0] msg_data;
  logic          ack_valid, ack_dirty;
  logic [NW-1:0] ack_node;
  logic [DW-1:0] ack_data;
  logic [LW-1:0] mem_line;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic          mem_we;

  always #10 clk = ~clk;

  home_dir_ctrl #(.NODES(NODES), .LINES(LINES), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
    .req_line(req_line), .req_excl(req_excl),
    .msg_valid(msg_valid), .msg_node(msg_node), .msg_kind(msg_kind),
    .msg_line(msg_line), .msg_data(msg_data),
    .ack_valid(ack_valid), .ack_node(ack_node), .ack_dirty(ack_dirty), .ack_data(ack_data),
    .mem_line(mem_line), .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  function automatic logic [DW-1:0] init_word(input int l);
    return 32'hA000_0000 + 32'(l) * 32'h0000_0101;
  endfunction

  // backing memory
  logic [DW-1:0] mem_arr [LINES];
  assign mem_rdata = mem_arr[mem_line];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem_arr[i] <= init_word(i);
    end else if (mem_we) begin
      mem_arr[mem_line] <= mem_wdata;
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // scoreboard queues
  int            q_kind[$], q_node[$], q_line[$];
  logic [DW-1:0] q_data[$], q_adata[$];
  bit            q_dirty[$];
  string         q_tag[$];

  int            a_node[$], a_rel[$];
  bit            a_dirty[$];
  logic [DW-1:0] a_data[$];

  int acks_owed = 0;
  int ack_dly   = 1;
  bit stray_arm = 0;
  int stray_node = 0;

  task automatic push_exp(input int k, input int n, input int l, input logic [DW-1:0] d,
                          input bit dirty, input logic [DW-1:0] ad, input string tag);
    q_kind.push_back(k); q_node.push_back(n); q_line.push_back(l);
    q_data.push_back(d); q_dirty.push_back(dirty); q_adata.push_back(ad);
    q_tag.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid) begin
      if (q_kind.size() == 0) begin
        chk(1'b0, "R3", "message with nothing expected, node", 64'(msg_node), 64'd0);
      end else begin
        int k, n, l;
        logic [DW-1:0] d, ad;
        bit dirty;
        string tag;
        k = q_kind.pop_front(); n = q_node.pop_front(); l = q_line.pop_front();
        d = q_data.pop_front(); dirty = q_dirty.pop_front(); ad = q_adata.pop_front();
        tag = q_tag.pop_front();
        chk((msg_kind == 2'(k)) && (msg_node == NW'(n)) && (msg_line == LW'(l)) && (msg_data == d),
            tag, "message {kind,node,line,data}",
            64'({msg_kind, msg_node, msg_line, msg_data}),
            64'({2'(k), NW'(n), LW'(l), d}));
        if (k >= 2) begin
          a_node.push_back(n); a_dirty.push_back(dirty); a_data.push_back(ad);
          a_rel.push_back(cyc + ack_dly);
          acks_owed++;
        end else begin
          chk(acks_owed == 0, "R4", "acknowledgements still owed at fill", 64'(acks_owed), 64'd0);
        end
      end
    end
  end

  // node responder
  initial begin
    ack_valid = 1'b0; ack_node = '0; ack_dirty = 1'b0; ack_data = '0;
    forever begin
      @(negedge clk);
      #2;
      if (stray_arm && acks_owed > 0) begin
        ack_valid = 1'b1; ack_node = NW'(stray_node); ack_dirty = 1'b1;
        ack_data = 32'hBAD0_BAD0;
        stray_arm = 0;
      end else if (a_node.size() > 0 && cyc >= a_rel[0]) begin
        ack_valid = 1'b1;
        ack_node  = NW'(a_node.pop_front());
        ack_dirty = a_dirty.pop_front();
        ack_data  = a_data.pop_front();
        void'(a_rel.pop_front());
        acks_owed--;
      end else begin
        ack_valid = 1'b0; ack_dirty = 1'b0;
      end
    end
  end

  // bench-side directory model
  int               dst  [LINES];   // 0 invalid, 1 shared, 2 modified
  logic [NODES-1:0] dsh  [LINES];
  int               down [LINES];
  logic [DW-1:0]    dval [LINES];
  logic [DW-1:0]    memm [LINES];
  int               seq = 0;

  task automatic do_req(input int n, input int l, input bit x, input string tag);
    logic [NODES-1:0] hold, tgt;
    int nsn, cycles, bad;
    nsn = 0;
    hold = (dst[l] == 2) ? NODES'(1 << down[l]) : dsh[l];
    if (x) begin
      tgt = hold & ~NODES'(1 << n);
      for (int i = 0; i < NODES; i++) begin
        if (tgt[i]) begin
          push_exp(2, i, l, '0, dst[l] == 2, dval[l], tag);
          nsn++;
        end
      end
      if (dst[l] == 2 && down[l] != n) memm[l] = dval[l];
      push_exp(1, n, l, memm[l], 1'b0, '0, tag);
      dst[l] = 2; down[l] = n; dsh[l] = '0;
      seq++;
      dval[l] = 32'hD000_0000 | (32'(l) << 12) | (32'(n) << 8) | 32'(seq);
    end else begin
      if (dst[l] == 2 && down[l] != n) begin
        push_exp(3, down[l], l, '0, 1'b1, dval[l], tag);
        nsn++;
        memm[l] = dval[l];
      end
      push_exp(0, n, l, memm[l], 1'b0, '0, tag);
      dst[l] = 1; dsh[l] = hold | NODES'(1 << n);
    end
    @(negedge clk);
    req_valid = 1'b1; req_node = NW'(n); req_line = LW'(l); req_excl = x;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 0; bad = 0;
    while (q_kind.size() > 0 && cycles < 1000) begin
      @(negedge clk);
      #1;
      cycles++;
      if (q_kind.size() > 0 && req_ready) bad++;
    end
    chk(bad == 0, "R9", "cycles with req_ready high while busy", 64'(bad), 64'd0);
    if (nsn == 0) chk(cycles == 1, "R10", "fill latency after lookup", 64'(cycles), 64'd1);
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R9", "req_ready after fill", 64'(req_ready), 64'd1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      dst[i] = 0; dsh[i] = '0; down[i] = 0; dval[i] = '0; memm[i] = init_word(i);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_node = '0; req_line = '0; req_excl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    chk(msg_valid == 1'b0, "R1", "msg_valid after reset", 64'(msg_valid), 64'd0);
    chk(mem_we == 1'b0, "R1", "mem_we after reset", 64'(mem_we), 64'd0);

    // R2 reads of invalid and shared lines
    do_req(0, 1, 1'b0, "R1");
    do_req(1, 1, 1'b0, "R2");
    do_req(2, 1, 1'b0, "R2");

    // R3 R4 three sharers invalidated, stray dirty ack from requester ignored
    ack_dly = 4; stray_node = 3; stray_arm = 1;
    do_req(3, 1, 1'b1, "R3");
    chk(mem_arr[1] == init_word(1), "R4", "memory untouched by stray ack",
        64'(mem_arr[1]), 64'(init_word(1)));

    // R6 read of a modified line recalls the owner
    ack_dly = 2;
    do_req(0, 1, 1'b0, "R6");
    chk(mem_arr[1] == memm[1], "R6", "written-back memory word", 64'(mem_arr[1]), 64'(memm[1]));

    // R5 R3 owner plus reader: exclusive by owner snoops only the reader
    do_req(3, 1, 1'b1, "R3");

    // R8 sole-sharer upgrade, then owner re-request
    do_req(2, 2, 1'b0, "R2");
    do_req(2, 2, 1'b1, "R8");
    do_req(2, 2, 1'b1, "R8");

    // R7 exclusive on a line modified elsewhere
    ack_dly = 3;
    do_req(1, 2, 1'b1, "R7");
    chk(mem_arr[2] == memm[2], "R7", "written-back memory word", 64'(mem_arr[2]), 64'(memm[2]));

    // R5 next writer snoops only the recorded owner
    ack_dly = 1;
    do_req(0, 2, 1'b1, "R5");

    // R2 read to an untouched line, R8 exclusive on an invalid line
    do_req(1, 5, 1'b0, "R2");
    do_req(2, 6, 1'b1, "R8");
    do_req(3, 6, 1'b0, "R6");

    repeat (5) @(negedge clk);
    chk(q_kind.size() == 0, "R3", "expected messages left over", 64'(q_kind.size()), 64'd0);
    chk(a_node.size() == 0, "R4", "acknowledgements left over", 64'(a_node.size()), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule